// File: doc/BRIEF.md
# Indirect Routing Entry Register Window

This block is the software-visible front end of an I/O interrupt controller. A simple bus slave exposes two registers at fixed offsets: an 8-bit index register and a 32-bit data window. The index chooses what the window reaches. It can reach an identification register, a read-only version word, or one 32-bit half of a 64-bit routing entry. There is one routing entry per interrupt input pin.

The block stores the routing table and drives the decoded fields of every entry to the delivery logic in parallel. The delivery logic sends back set and clear requests for two status flags in each entry: the remote-pending flag and the delivery-status flag. Software cannot overwrite these flags through the window. After every accepted table write, a single-cycle notice names the entry that changed. The delivery logic can then re-examine a level-triggered pin that is still asserted.

Top module: `irq_route_regs`

## Requirements
- R1: Only bus offset 0x00 (index register) and offset 0x10 (data window) respond. A read at any other offset returns zero, and a write there changes nothing.
- R2: A write to the index register stores the low 8 bits of the write data. Reading offset 0x00 returns that value in bits 7:0, with zeros above.
- R3: Index 0x01 reads as the pin count minus one in bits 23:16 and the version code in bits 7:0, with every other bit zero. Writes at index 0x01 are ignored.
- R4: Index 0x00 holds a 4-bit identifier, written from and read at window bits 27:24. Index 0x02 reads the same identifier, and writes at index 0x02 are ignored.
- R5: For an index of 0x10 or above, the entry number is (index − 0x10) / 2. An odd index reaches entry bits 63:32 and an even index reaches bits 31:0. A write replaces the whole 32-bit half.
- R6: When the index is 0x03 to 0x0F, or names an entry number at or beyond the pin count, a window read returns all ones and a window write is discarded.
- R7: A window write to an entry leaves delivery status (bit 12) and remote-pending (bit 14) at the values they held, whatever data is written in those positions.
- R8: After a window write, if the entry's trigger bit (bit 15, 1 = level) is 0, remote-pending reads 0.
- R9: Reset sets the mask bit (bit 16) of every entry and clears all other entry bits, the index register and the identifier.
- R10: The per-pin outputs give each entry's fields: vector bits 7:0, delivery mode bits 10:8, destination mode bit 11, delivery status bit 12, remote-pending bit 14, trigger bit 15, mask bit 16, and destination bits 63:56.
- R11: In the cycle after an accepted entry write, `upd_valid` is high for one cycle and `upd_index` carries the entry number. No other access raises `upd_valid`.
- R12: Access size code 0 is byte, 1 is halfword, and 2 or 3 is word. Write data is cut to that many low bytes and zero-extended. Read data is masked to the same bytes.
- R13: Hardware set and clear requests change remote-pending and delivery status one cycle later. A clear wins over a set in the same cycle. A software write in that cycle keeps the value after the hardware request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset within the register window |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access size code |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| hw_remote_set | input | PINS | Set remote-pending, one bit per pin |
| hw_remote_clr | input | PINS | Clear remote-pending, one bit per pin |
| hw_status_set | input | PINS | Set delivery status, one bit per pin |
| hw_status_clr | input | PINS | Clear delivery status, one bit per pin |
| ent_vector | output | PINS*8 | Vector of each entry |
| ent_dlv_mode | output | PINS*3 | Delivery mode of each entry |
| ent_dest_mode | output | PINS | Destination mode of each entry |
| ent_dlv_status | output | PINS | Delivery status of each entry |
| ent_remote | output | PINS | Remote-pending of each entry |
| ent_level | output | PINS | Trigger mode of each entry, 1 = level |
| ent_mask | output | PINS | Mask of each entry |
| ent_dest_id | output | PINS*8 | Destination of each entry |
| upd_valid | output | 1 | One-cycle notice of an entry write |
| upd_index | output | IDX_W | Entry number of that write |

## Verification
The assertions check four things on every cycle. Unmapped offsets must read zero, and an out-of-range index must read all ones at the access width. The index register must follow its last write, and every update notice must come from a window write. After a write notice, the named entry must keep its delivery status when hardware did not touch it, and must show no remote-pending when it is edge-triggered. The bench scenarios show what no single-cycle property can. These are the exact half-entry mapping, zero-extension of narrow writes, and the reset contents of the whole table. They also show the ordering of a hardware request against a software write in the same cycle, and that ignored writes to the version, arbitration and out-of-range indexes change no visible state.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [7:0] OFS_SELECT  = 8'h00;
  localparam logic [7:0] OFS_WINDOW  = 8'h10;

  localparam logic [7:0] IDX_IDENT   = 8'h00;
  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam logic [7:0] IDX_ARBIT   = 8'h02;
  localparam logic [7:0] IDX_TABLE   = 8'h10;

  localparam int POS_VECTOR  = 0;
  localparam int POS_DLVMODE = 8;
  localparam int POS_DSTMODE = 11;
  localparam int POS_STATUS  = 12;
  localparam int POS_REMOTE  = 14;
  localparam int POS_LEVEL   = 15;
  localparam int POS_MASK    = 16;
  localparam int POS_DESTID  = 56;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_HALF  = 2'd1,
    ACC_WORD  = 2'd2,
    ACC_DWORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [7:0] dest_id;
    logic       mask;
    logic       level;
    logic       remote;
    logic       status;
    logic       dest_mode;
    logic [2:0] dlv_mode;
    logic [7:0] vector;
  } route_fields_t;

  function automatic logic [31:0] lane_mask(logic [1:0] sz);
    logic [31:0] m;
    case (acc_size_e'(sz))
      ACC_BYTE: m = 32'h0000_00ff;
      ACC_HALF: m = 32'h0000_ffff;
      default:  m = 32'hffff_ffff;
    endcase
    return m;
  endfunction

  function automatic logic [6:0] table_slot(logic [7:0] sel);
    logic [7:0] d;
    d = sel - IDX_TABLE;
    return d[7:1];
  endfunction

  function automatic logic [63:0] entry_reset_value();
    logic [63:0] e;
    e = '0;
    e[POS_MASK] = 1'b1;
    return e;
  endfunction

  function automatic logic [63:0] sw_merge(logic [63:0] cur, logic [31:0] data,
                                           logic upper);
    logic [63:0] n;
    n = upper ? {data, cur[31:0]} : {cur[63:32], data};
    n[POS_STATUS] = cur[POS_STATUS];
    n[POS_REMOTE] = cur[POS_REMOTE];
    if (!n[POS_LEVEL]) n[POS_REMOTE] = 1'b0;
    return n;
  endfunction

  function automatic route_fields_t unpack_entry(logic [63:0] e);
    route_fields_t f;
    f.vector    = e[POS_VECTOR +: 8];
    f.dlv_mode  = e[POS_DLVMODE +: 3];
    f.dest_mode = e[POS_DSTMODE];
    f.status    = e[POS_STATUS];
    f.remote    = e[POS_REMOTE];
    f.level     = e[POS_LEVEL];
    f.mask      = e[POS_MASK];
    f.dest_id   = e[POS_DESTID +: 8];
    return f;
  endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int PINS = 24,
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic [1:0]       bus_size,
  input  logic [7:0]       sel_q,
  output logic             hit_sel,
  output logic             hit_win,
  output logic             wr_sel,
  output logic             wr_ident,
  output logic             tbl_hit,
  output logic             tbl_we,
  output logic [IDX_W-1:0] tbl_idx,
  output logic [31:0]      wdata_ext
);
  logic [6:0] slot;

  assign hit_sel   = (bus_addr == OFS_SELECT);
  assign hit_win   = (bus_addr == OFS_WINDOW);
  assign wdata_ext = bus_wdata & lane_mask(bus_size);

  assign slot    = table_slot(sel_q);
  assign tbl_hit = (sel_q >= IDX_TABLE) && (int'(slot) < PINS);
  assign tbl_idx = slot[IDX_W-1:0];

  assign wr_sel   = bus_wr && hit_sel;
  assign wr_ident = bus_wr && hit_win && (sel_q == IDX_IDENT);
  assign tbl_we   = bus_wr && hit_win && tbl_hit;
endmodule

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic        upper,
  input  logic [31:0] wdata,
  input  logic        rem_set,
  input  logic        rem_clr,
  input  logic        st_set,
  input  logic        st_clr,
  output logic [63:0] bits_q
);
  logic [63:0] hw_bits;
  logic [63:0] nxt_bits;

  always_comb begin
    hw_bits = bits_q;
    if (rem_clr)      hw_bits[POS_REMOTE] = 1'b0;
    else if (rem_set) hw_bits[POS_REMOTE] = 1'b1;
    if (st_clr)       hw_bits[POS_STATUS] = 1'b0;
    else if (st_set)  hw_bits[POS_STATUS] = 1'b1;
    nxt_bits = we ? sw_merge(hw_bits, wdata, upper) : hw_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= entry_reset_value();
    else        bits_q <= nxt_bits;
  end
endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int PINS = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11,
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic [7:0]       sel_q,
  input  logic [3:0]       ident_q,
  input  logic             tbl_hit,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [PINS*64-1:0] tbl_flat,
  output logic [31:0]      win_data
);
  localparam logic [7:0] LAST_PIN = 8'(PINS - 1);
  logic [63:0] pick;

  always_comb begin
    pick = '1;
    for (int i = 0; i < PINS; i++) begin
      if (tbl_idx == IDX_W'(i)) pick = tbl_flat[i*64 +: 64];
    end
  end

  always_comb begin
    case (sel_q)
      IDX_IDENT, IDX_ARBIT: win_data = {4'h0, ident_q, 24'h0};
      IDX_VERSION:          win_data = {8'h00, LAST_PIN, 8'h00, VERSION_CODE};
      default:              win_data = tbl_hit ? (sel_q[0] ? pick[63:32] : pick[31:0])
                                               : 32'hffff_ffff;
    endcase
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int PINS = 24,
  parameter logic [7:0] VERSION_CODE = 8'h11,
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  input  logic [1:0]         bus_size,
  output logic [31:0]        bus_rdata,
  input  logic [PINS-1:0]    hw_remote_set,
  input  logic [PINS-1:0]    hw_remote_clr,
  input  logic [PINS-1:0]    hw_status_set,
  input  logic [PINS-1:0]    hw_status_clr,
  output logic [PINS*8-1:0]  ent_vector,
  output logic [PINS*3-1:0]  ent_dlv_mode,
  output logic [PINS-1:0]    ent_dest_mode,
  output logic [PINS-1:0]    ent_dlv_status,
  output logic [PINS-1:0]    ent_remote,
  output logic [PINS-1:0]    ent_level,
  output logic [PINS-1:0]    ent_mask,
  output logic [PINS*8-1:0]  ent_dest_id,
  output logic               upd_valid,
  output logic [IDX_W-1:0]   upd_index
);
  logic [7:0]         sel_q;
  logic [3:0]         ident_q;
  logic               hit_sel, hit_win, wr_sel, wr_ident;
  logic               tbl_hit, tbl_we;
  logic [IDX_W-1:0]   tbl_idx;
  logic [31:0]        wdata_ext;
  logic [31:0]        win_data;
  logic [PINS*64-1:0] tbl_flat;

  irq_route_decode #(.PINS(PINS)) u_dec (
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_size (bus_size),
    .sel_q    (sel_q),
    .hit_sel  (hit_sel),
    .hit_win  (hit_win),
    .wr_sel   (wr_sel),
    .wr_ident (wr_ident),
    .tbl_hit  (tbl_hit),
    .tbl_we   (tbl_we),
    .tbl_idx  (tbl_idx),
    .wdata_ext(wdata_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      ident_q <= '0;
    end else begin
      if (wr_sel)   sel_q   <= wdata_ext[7:0];
      if (wr_ident) ident_q <= wdata_ext[27:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_index <= '0;
    end else begin
      upd_valid <= tbl_we;
      if (tbl_we) upd_index <= tbl_idx;
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : g_ent
    logic          ent_we;
    route_fields_t fld;

    assign ent_we = tbl_we && (tbl_idx == IDX_W'(g));

    irq_route_entry u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ent_we),
      .upper  (sel_q[0]),
      .wdata  (wdata_ext),
      .rem_set(hw_remote_set[g]),
      .rem_clr(hw_remote_clr[g]),
      .st_set (hw_status_set[g]),
      .st_clr (hw_status_clr[g]),
      .bits_q (tbl_flat[g*64 +: 64])
    );

    assign fld = unpack_entry(tbl_flat[g*64 +: 64]);
    assign ent_vector[g*8 +: 8]   = fld.vector;
    assign ent_dlv_mode[g*3 +: 3] = fld.dlv_mode;
    assign ent_dest_mode[g]       = fld.dest_mode;
    assign ent_dlv_status[g]      = fld.status;
    assign ent_remote[g]          = fld.remote;
    assign ent_level[g]           = fld.level;
    assign ent_mask[g]            = fld.mask;
    assign ent_dest_id[g*8 +: 8]  = fld.dest_id;
  end

  irq_route_rdmux #(.PINS(PINS), .VERSION_CODE(VERSION_CODE)) u_rd (
    .sel_q   (sel_q),
    .ident_q (ident_q),
    .tbl_hit (tbl_hit),
    .tbl_idx (tbl_idx),
    .tbl_flat(tbl_flat),
    .win_data(win_data)
  );

  always_comb begin
    if (hit_sel)      bus_rdata = {24'h0, sel_q};
    else if (hit_win) bus_rdata = win_data;
    else              bus_rdata = '0;
    bus_rdata = bus_rdata & lane_mask(bus_size);
  end
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk #(
  parameter int PINS = 24,
  localparam int IDX_W = (PINS > 1) ? $clog2(PINS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic [1:0]       bus_size,
  input logic [31:0]      bus_rdata,
  input logic [7:0]       sel_q,
  input logic             upd_valid,
  input logic [IDX_W-1:0] upd_index,
  input logic [PINS-1:0]  ent_level,
  input logic [PINS-1:0]  ent_remote,
  input logic [PINS-1:0]  ent_dlv_status,
  input logic [PINS-1:0]  hw_status_set,
  input logic [PINS-1:0]  hw_status_clr
);
  logic [PINS-1:0] prev_status;
  logic [PINS-1:0] prev_hw_touch;
  logic [31:0]     size_bytes;
  logic            idx_void;
  logic            sel_written;
  logic [7:0]      sel_expect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_status   <= '0;
      prev_hw_touch <= '0;
      sel_written   <= 1'b0;
      sel_expect    <= '0;
    end else begin
      prev_status   <= ent_dlv_status;
      prev_hw_touch <= hw_status_set | hw_status_clr;
      sel_written   <= bus_wr && (bus_addr == 8'h00);
      sel_expect    <= bus_wdata[7:0];
    end
  end

  assign size_bytes = (bus_size == 2'd0) ? 32'hff :
                      (bus_size == 2'd1) ? 32'hffff : 32'hffff_ffff;
  assign idx_void = (sel_q < 8'h10) ? (sel_q > 8'h02)
                                    : ((int'(sel_q) - 16) / 2 >= PINS);

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != 8'h00 && bus_addr != 8'h10) |-> bus_rdata == 32'h0); // R1
  AST_SELECT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_written |-> sel_q == sel_expect); // R2
  AST_VOID_INDEX_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h10 && idx_void) |-> bus_rdata == size_bytes); // R6
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !prev_hw_touch[upd_index])
      |-> ent_dlv_status[upd_index] == prev_status[upd_index]); // R7
  AST_EDGE_NO_REMOTE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !ent_level[upd_index]) |-> !ent_remote[upd_index]); // R8
  AST_NOTICE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ($past(bus_wr) && $past(bus_addr) == 8'h10 && $past(sel_q) >= 8'h10)); // R11
endmodule

bind irq_route_regs irq_route_chk #(.PINS(PINS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_wdata     (bus_wdata),
  .bus_size      (bus_size),
  .bus_rdata     (bus_rdata),
  .sel_q         (sel_q),
  .upd_valid     (upd_valid),
  .upd_index     (upd_index),
  .ent_level     (ent_level),
  .ent_remote    (ent_remote),
  .ent_dlv_status(ent_dlv_status),
  .hw_status_set (hw_status_set),
  .hw_status_clr (hw_status_clr)
);

// File: tb/sim_irq_route_regs.sv
module sim_irq_route_regs;
  localparam int PINS = 24;
  localparam int IW = 5;
  localparam logic [7:0] VER = 8'h11;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  b_addr = '0;
  logic        b_wr = 1'b0;
  logic [31:0] b_wdata = '0;
  logic [1:0]  b_size = 2'd2;
  logic [31:0] b_rdata;
  logic [PINS-1:0] h_rs = '0, h_rc = '0, h_ss = '0, h_sc = '0;
  logic [PINS*8-1:0] o_vec, o_dst;
  logic [PINS*3-1:0] o_dm;
  logic [PINS-1:0] o_dmode, o_st, o_rem, o_lvl, o_msk;
  logic o_uv;
  logic [IW-1:0] o_ui;

  irq_route_regs #(.PINS(PINS), .VERSION_CODE(VER)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wr(b_wr),
    .bus_wdata(b_wdata), .bus_size(b_size), .bus_rdata(b_rdata),
    .hw_remote_set(h_rs), .hw_remote_clr(h_rc),
    .hw_status_set(h_ss), .hw_status_clr(h_sc),
    .ent_vector(o_vec), .ent_dlv_mode(o_dm), .ent_dest_mode(o_dmode),
    .ent_dlv_status(o_st), .ent_remote(o_rem), .ent_level(o_lvl),
    .ent_mask(o_msk), .ent_dest_id(o_dst), .upd_valid(o_uv), .upd_index(o_ui)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [63:0] m_tbl [PINS];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  bit          e_uv;
  int          e_ui;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] szm(input logic [1:0] s);
    if (s == 2'd0) return 32'h0000_00ff;
    if (s == 2'd1) return 32'h0000_ffff;
    return 32'hffff_ffff;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [1:0] s);
    logic [31:0] r;
    int k;
    r = 32'h0;
    if (a == 8'h00) r = {24'h0, m_sel};
    else if (a == 8'h10) begin
      if (m_sel == 8'h00 || m_sel == 8'h02) r = {4'h0, m_id, 24'h0};
      else if (m_sel == 8'h01) r = {8'h0, 8'(PINS - 1), 8'h0, VER};
      else if (m_sel < 8'h10) r = 32'hffff_ffff;
      else begin
        k = (int'(m_sel) - 16) / 2;
        if (k >= PINS) r = 32'hffff_ffff;
        else r = m_sel[0] ? m_tbl[k][63:32] : m_tbl[k][31:0];
      end
    end
    return r & szm(s);
  endfunction

  task automatic commit();
    logic [31:0] d;
    logic k12, k14;
    int k;
    e_uv = 1'b0;
    for (int i = 0; i < PINS; i++) begin
      if (h_rc[i]) m_tbl[i][14] = 1'b0; else if (h_rs[i]) m_tbl[i][14] = 1'b1;
      if (h_sc[i]) m_tbl[i][12] = 1'b0; else if (h_ss[i]) m_tbl[i][12] = 1'b1;
    end
    if (b_wr) begin
      d = b_wdata & szm(b_size);
      if (b_addr == 8'h00) m_sel = d[7:0];
      else if (b_addr == 8'h10) begin
        if (m_sel == 8'h00) m_id = d[27:24];
        else if (m_sel >= 8'h10) begin
          k = (int'(m_sel) - 16) / 2;
          if (k < PINS) begin
            k12 = m_tbl[k][12];
            k14 = m_tbl[k][14];
            if (m_sel[0]) m_tbl[k][63:32] = d; else m_tbl[k][31:0] = d;
            m_tbl[k][12] = k12;
            m_tbl[k][14] = m_tbl[k][15] ? k14 : 1'b0;
            e_uv = 1'b1;
            e_ui = k;
          end
        end
      end
    end
  endtask

  task automatic check_fields();
    logic [PINS*8-1:0] ev, ed;
    logic [PINS*3-1:0] em;
    logic [PINS-1:0] edm, est, erm, elv, emk;
    for (int i = 0; i < PINS; i++) begin
      ev[i*8 +: 8] = m_tbl[i][7:0];
      em[i*3 +: 3] = m_tbl[i][10:8];
      edm[i] = m_tbl[i][11];
      est[i] = m_tbl[i][12];
      erm[i] = m_tbl[i][14];
      elv[i] = m_tbl[i][15];
      emk[i] = m_tbl[i][16];
      ed[i*8 +: 8] = m_tbl[i][63:56];
    end
    chk({o_vec, o_dm, o_dmode, o_dst} == {ev, em, edm, ed}, "R10 fields",
        {o_vec[31:0], o_dst[31:0]}, {ev[31:0], ed[31:0]});
    chk({o_st, o_rem, o_lvl, o_msk} == {est, erm, elv, emk}, "R13 status flags",
        {o_st, o_rem}, {est, erm});
    chk(o_uv == e_uv && (!e_uv || int'(o_ui) == e_ui), "R11 update notice",
        {o_uv, 3'b0, o_ui}, {e_uv, 32'(e_ui)});
  endtask

  task automatic cyc();
    string tag;
    #1;
    tag = (b_addr == 8'h00) ? "R2 read" : (b_addr == 8'h10) ? "R5 read" : "R1 read";
    chk(b_rdata == exp_read(b_addr, b_size), tag, b_rdata, exp_read(b_addr, b_size));
    @(posedge clk);
    commit();
    #1;
    check_fields();
    b_wr = 1'b0;
    h_rs = '0; h_rc = '0; h_ss = '0; h_sc = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] s);
    b_addr = a; b_wdata = d; b_size = s; b_wr = 1'b1;
    cyc();
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] s, input logic [31:0] exp,
                    input string tag);
    b_addr = a; b_size = s; b_wr = 1'b0;
    #1;
    chk(b_rdata == exp, tag, b_rdata, exp);
    cyc();
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5eed_1234);
    for (int i = 0; i < PINS; i++) m_tbl[i] = 64'h1 << 16;
    m_sel = 8'h00; m_id = 4'h0; e_uv = 1'b0; e_ui = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    chk(o_msk == '1 && o_rem == '0 && o_st == '0 && o_vec == '0, "R9 reset entries",
        {o_msk, o_vec[7:0]}, {24'hffffff, 8'h00});
    rd(8'h00, 2'd2, 32'h0, "R9 reset select");
    rd(8'h10, 2'd2, 32'h0, "R9 reset identifier");

    // R1 unmapped offsets
    wr(8'h04, 32'h0000_0055, 2'd2);
    rd(8'h04, 2'd2, 32'h0, "R1 unmapped read");
    rd(8'h00, 2'd2, 32'h0, "R1 unmapped write ignored");

    // R2 select keeps low byte
    wr(8'h00, 32'h0000_1234, 2'd2);
    rd(8'h00, 2'd2, 32'h0000_0034, "R2 select low byte");

    // R3 version
    wr(8'h00, 32'h1, 2'd2);
    rd(8'h10, 2'd2, 32'h0017_0011, "R3 version word");
    wr(8'h10, 32'hffff_ffff, 2'd2);
    rd(8'h10, 2'd2, 32'h0017_0011, "R3 version write ignored");

    // R4 identifier and arbitration alias
    wr(8'h00, 32'h0, 2'd2);
    wr(8'h10, 32'ha500_0000, 2'd2);
    rd(8'h10, 2'd2, 32'h0500_0000, "R4 identifier");
    wr(8'h00, 32'h2, 2'd2);
    rd(8'h10, 2'd2, 32'h0500_0000, "R4 arbitration alias");
    wr(8'h10, 32'h0f00_0000, 2'd2);
    wr(8'h00, 32'h0, 2'd2);
    rd(8'h10, 2'd2, 32'h0500_0000, "R4 arbitration write ignored");

    // R5, R10, R11 entry halves
    wr(8'h00, 32'h12, 2'd2);
    wr(8'h10, 32'h0000_0b42, 2'd2);
    wr(8'h00, 32'h13, 2'd2);
    b_addr = 8'h10; b_wdata = 32'h7e00_0000; b_size = 2'd2; b_wr = 1'b1;
    cyc();
    chk(o_uv == 1'b1 && o_ui == 5'd1, "R11 notice index", {o_uv, o_ui}, {1'b1, 5'd1});
    chk(o_vec[15:8] == 8'h42 && o_dm[5:3] == 3'd3 && o_dmode[1] && !o_msk[1] &&
        o_dst[15:8] == 8'h7e, "R10 decoded entry one", o_vec[15:8], 8'h42);
    rd(8'h10, 2'd2, 32'h7e00_0000, "R5 upper half");
    chk(o_uv == 1'b0, "R11 notice one cycle", o_uv, 1'b0);
    wr(8'h00, 32'h12, 2'd2);
    rd(8'h10, 2'd2, 32'h0000_0b42, "R5 lower half");

    // R12 access size
    wr(8'h10, 32'hffff_ff99, 2'd0);
    rd(8'h10, 2'd1, 32'h0000_0099, "R12 byte write zero-extended");
    wr(8'h00, 32'h13, 2'd2);
    rd(8'h10, 2'd0, 32'h0000_0000, "R12 byte read masked");

    // R6 void indexes
    wr(8'h00, 32'h07, 2'd2);
    rd(8'h10, 2'd2, 32'hffff_ffff, "R6 reserved index");
    wr(8'h00, 32'h40, 2'd2);
    rd(8'h10, 2'd1, 32'h0000_ffff, "R6 beyond last pin");
    b_addr = 8'h10; b_wdata = 32'h0; b_size = 2'd2; b_wr = 1'b1;
    cyc();
    chk(o_uv == 1'b0 && o_msk == ~24'h2, "R6 write discarded", {o_uv, o_msk}, {1'b0, ~24'h2});

    // R7, R8, R13 hardware-owned flags on pin 3
    wr(8'h00, 32'h16, 2'd2);
    wr(8'h10, 32'h0000_8031, 2'd2);
    h_rs[3] = 1'b1; h_ss[3] = 1'b1;
    b_addr = 8'h10; b_size = 2'd2;
    cyc();
    chk(o_rem[3] && o_st[3], "R13 hardware set", {o_rem[3], o_st[3]}, 2'b11);
    wr(8'h10, 32'h0000_8031, 2'd2);
    rd(8'h10, 2'd2, 32'h0000_d031, "R7 flags kept on write");
    wr(8'h10, 32'h0000_5031, 2'd2);
    rd(8'h10, 2'd2, 32'h0000_1031, "R8 edge clears remote");
    wr(8'h10, 32'h0000_8031, 2'd2);
    h_rs[3] = 1'b1; h_rc[3] = 1'b1; h_sc[3] = 1'b1;
    cyc();
    chk(!o_rem[3] && !o_st[3], "R13 clear wins", {o_rem[3], o_st[3]}, 2'b00);
    h_ss[3] = 1'b1; h_rs[3] = 1'b1;
    wr(8'h10, 32'h0000_0031, 2'd2);
    chk(o_st[3] && !o_rem[3], "R13 hardware before software", {o_st[3], o_rem[3]}, 2'b10);

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int pick;
      pick = $urandom_range(0, 9);
      b_addr = (pick < 7) ? 8'h10 : (pick < 9) ? 8'h00 : 8'($urandom_range(0, 255));
      b_wr = $urandom_range(0, 1);
      b_size = 2'($urandom_range(0, 3));
      b_wdata = $urandom;
      if (b_addr == 8'h00) b_wdata[7:0] = 8'($urandom_range(0, 8'h3f));
      h_rs = PINS'($urandom & $urandom & $urandom);
      h_rc = PINS'($urandom & $urandom & $urandom);
      h_ss = PINS'($urandom & $urandom & $urandom);
      h_sc = PINS'($urandom & $urandom & $urandom);
      cyc();
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule